// File: doc/BRIEF.md
# Snapshot Event Flag Store

This block holds a set of events, each made of an occurrence flag and a data value. Any number of producers post events through one emit port at any time, and the writes land in a working ("live") bank. A consuming task never looks at that bank. It reads only a second, frozen bank. The frozen bank changes only when a commit strobe is pulsed at the start of each task run.

On a commit, the whole live bank (flags and values) is captured into the frozen bank in a single clock edge, and the live flags are cleared. The consumer therefore sees one atomic snapshot of every event. Suppose one event can only be produced after another one has occurred. Then a snapshot can never show the later event without the earlier one.

Values are global: an event's value persists across commits until it is overwritten, and only the occurrence flags are cleared. The consumer reads one event at a time by index, and it can also see every frozen flag at once so that it can test several events together.

Top module: `evt_snapshot_store`

## Requirements
- R1: After reset, every flag and every value in both banks is zero. A commit made right after reset still shows all flags at 0 and all values at 0.
- R2: An emit (`emit_en`=1) writes `emit_val` and sets the flag of event `emit_idx` in the live bank only. The frozen outputs do not change until a commit.
- R3: `rd_flag` and `rd_val` show the frozen flag and value of the event selected by `rd_idx`, without delay. Bit i of `frz_flags` is the frozen flag of event i.
- R4: On a clock edge with `commit`=1, the frozen bank takes the live flags and values as they stood before that edge. The new contents are visible right after that edge.
- R5: On a commit edge, every live flag clears, except the flag of an emit made in the same cycle.
- R6: An emit made in the same cycle as a commit is not part of that snapshot. It is kept in the live bank and appears in the next snapshot.
- R7: If one event is emitted several times between commits, the snapshot shows its flag set and the value of the last emit.
- R8: Between commits, the frozen flags and values stay constant, whatever the producers do.
- R9: If event x is emitted strictly before event y and no commit falls between the two emits, then no snapshot shows y set with x clear.
- R10: A value is global. A commit of an event whose flag is clear still shows the last value written to that event, with the flag at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| emit_en | input | 1 | Producer posts an event this cycle |
| emit_idx | input | IDX_W | Index of the posted event |
| emit_val | input | VAL_W | Value of the posted event |
| commit | input | 1 | Task-start strobe; captures the snapshot |
| rd_idx | input | IDX_W | Consumer read index |
| rd_flag | output | 1 | Frozen occurrence flag of event `rd_idx` |
| rd_val | output | VAL_W | Frozen value of event `rd_idx` |
| frz_flags | output | NUM_EVT | All frozen occurrence flags |

## Verification
The bench targets the following corner cases:

- **Emit in the commit cycle.** The bench emits in the same cycle as a commit. A design that dropped that emit, or that leaked it into the current snapshot, would show a wrong flag at one of the two following commits.
- **Repeated emits.** The bench emits one event twice before a commit. A store that kept the first value, or that toggled the flag, would be caught here.
- **Emit order.** The bench emits two events in order and checks that they appear together in one snapshot. A design that cleared the live flags before the commit had captured them would leave an inconsistent snapshot.
- **Values after a commit.** The bench checks that values survive a commit while the flags are cleared. A design that cleared values along with flags would fail.
- **Reset.** The bench checks that a reset in the middle of a run clears both banks. A reset that spared the live bank would reappear at the next commit.

// File: rtl/evt_snapshot_store.sv
module evt_snapshot_store #(
  parameter int NUM_EVT = 8,
  parameter int VAL_W   = 16,
  parameter int IDX_W   = $clog2(NUM_EVT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               emit_en,
  input  logic [IDX_W-1:0]   emit_idx,
  input  logic [VAL_W-1:0]   emit_val,
  input  logic               commit,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic               rd_flag,
  output logic [VAL_W-1:0]   rd_val,
  output logic [NUM_EVT-1:0] frz_flags
);

  logic [NUM_EVT-1:0]            live_flag;
  logic [NUM_EVT-1:0][VAL_W-1:0] live_val;
  logic [NUM_EVT-1:0]            frz_flag;
  logic [NUM_EVT-1:0][VAL_W-1:0] frz_val;
  logic [NUM_EVT-1:0]            hit;

  always_comb begin
    for (int i = 0; i < NUM_EVT; i++)
      hit[i] = emit_en && (emit_idx == IDX_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_flag <= '0;
      live_val  <= '0;
      frz_flag  <= '0;
      frz_val   <= '0;
    end else begin
      if (commit) begin
        frz_flag <= live_flag;
        frz_val  <= live_val;
      end
      live_flag <= hit | (live_flag & {NUM_EVT{~commit}});
      for (int i = 0; i < NUM_EVT; i++)
        if (hit[i]) live_val[i] <= emit_val;
    end
  end

  assign rd_flag   = frz_flag[rd_idx];
  assign rd_val    = frz_val[rd_idx];
  assign frz_flags = frz_flag;

endmodule

module evt_snapshot_store_chk #(
  parameter int NUM_EVT = 8,
  parameter int VAL_W   = 16,
  parameter int IDX_W   = 3
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            emit_en,
  input logic [IDX_W-1:0]                emit_idx,
  input logic [VAL_W-1:0]                emit_val,
  input logic                            commit,
  input logic [NUM_EVT-1:0]              live_flag,
  input logic [NUM_EVT-1:0][VAL_W-1:0]   live_val,
  input logic [NUM_EVT-1:0]              frz_flags,
  input logic [NUM_EVT-1:0][VAL_W-1:0]   frz_val
);

  assert_frozen_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(frz_flags) && $stable(frz_val)));

  assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (frz_flags == $past(live_flag) && frz_val == $past(live_val)));

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !emit_en) |=> (live_flag == '0));

  assert_keep_emit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && emit_en) |=> ($countones(live_flag) == 1));

  assert_emit_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
    emit_en |=> (live_flag[$past(emit_idx)] && live_val[$past(emit_idx)] == $past(emit_val)));

endmodule

bind evt_snapshot_store evt_snapshot_store_chk #(
  .NUM_EVT(NUM_EVT), .VAL_W(VAL_W), .IDX_W(IDX_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .emit_en(emit_en), .emit_idx(emit_idx),
  .emit_val(emit_val), .commit(commit), .live_flag(live_flag),
  .live_val(live_val), .frz_flags(frz_flags), .frz_val(frz_val)
);

// File: tb/evt_snapshot_store_tb.sv
`timescale 1ns/1ps
module evt_snapshot_store_tb_top;
  localparam int NUM_EVT = 8;
  localparam int VAL_W   = 16;
  localparam int IDX_W   = 3;
  localparam int NVEC    = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic emit_en = 1'b0;
  logic [IDX_W-1:0] emit_idx = '0;
  logic [VAL_W-1:0] emit_val = '0;
  logic commit = 1'b0;
  logic [IDX_W-1:0] rd_idx = '0;
  logic rd_flag;
  logic [VAL_W-1:0] rd_val;
  logic [NUM_EVT-1:0] frz_flags;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  evt_snapshot_store #(.NUM_EVT(NUM_EVT), .VAL_W(VAL_W), .IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .emit_en(emit_en), .emit_idx(emit_idx),
    .emit_val(emit_val), .commit(commit), .rd_idx(rd_idx),
    .rd_flag(rd_flag), .rd_val(rd_val), .frz_flags(frz_flags)
  );

  // {emit_en, emit_idx, emit_val, commit, rd_idx, exp_flag, exp_val}
  localparam logic [40:0] VEC [NVEC] = '{
    {1'b1, 3'd2, 16'h1111, 1'b0, 3'd2, 1'b0, 16'h0000},  // R2
    {1'b1, 3'd5, 16'h5555, 1'b0, 3'd2, 1'b0, 16'h0000},  // R2 R8
    {1'b1, 3'd2, 16'h2222, 1'b0, 3'd5, 1'b0, 16'h0000},  // R8
    {1'b0, 3'd0, 16'h0000, 1'b1, 3'd2, 1'b1, 16'h2222},  // R4 R7
    {1'b0, 3'd0, 16'h0000, 1'b0, 3'd5, 1'b1, 16'h5555},  // R3
    {1'b1, 3'd0, 16'hAAAA, 1'b1, 3'd2, 1'b0, 16'h2222},  // R5 R10
    {1'b0, 3'd0, 16'h0000, 1'b1, 3'd0, 1'b1, 16'hAAAA},  // R6
    {1'b1, 3'd7, 16'h7777, 1'b0, 3'd7, 1'b0, 16'h0000},  // R2
    {1'b1, 3'd3, 16'h3333, 1'b1, 3'd7, 1'b1, 16'h7777},  // R4 R6
    {1'b1, 3'd1, 16'h0101, 1'b0, 3'd3, 1'b0, 16'h0000},  // R8
    {1'b0, 3'd0, 16'h0000, 1'b1, 3'd3, 1'b1, 16'h3333},  // R6
    {1'b0, 3'd0, 16'h0000, 1'b0, 3'd1, 1'b1, 16'h0101},  // R3
    {1'b0, 3'd0, 16'h0000, 1'b1, 3'd1, 1'b0, 16'h0101}   // R5 R10
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic [IDX_W-1:0] idx,
                      input logic [VAL_W-1:0] val, input logic cm);
    @(negedge clk);
    emit_en = en; emit_idx = idx; emit_val = val; commit = cm;
    @(posedge clk);
    #1;
    emit_en = 1'b0; commit = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 reset flags", 32'(frz_flags), 32'h0);

    for (int v = 0; v < NVEC; v++) begin
      logic [40:0] e;
      e = VEC[v];
      rd_idx = e[19:17];
      step(e[40], e[39:37], e[36:21], e[20]);
      check($sformatf("R3/R4 vec %0d flag", v), 32'(rd_flag), 32'(e[16]));
      check($sformatf("R3/R4 vec %0d value", v), 32'(rd_val), 32'(e[15:0]));
    end

    // R9: x=4 then y=6, then commit: both in the snapshot
    step(1'b0, 3'd0, 16'h0, 1'b1);
    step(1'b1, 3'd4, 16'h0044, 1'b0);
    step(1'b1, 3'd6, 16'h0066, 1'b0);
    check("R9 before commit", 32'(frz_flags), 32'h00);
    step(1'b0, 3'd0, 16'h0, 1'b1);
    check("R9 snapshot pair", 32'(frz_flags), 32'h50);

    // R6/R9: x, then y emitted in the commit cycle: x only
    step(1'b1, 3'd4, 16'h0144, 1'b0);
    step(1'b1, 3'd6, 16'h0166, 1'b1);
    check("R6 R9 x without y", 32'(frz_flags), 32'h10);
    rd_idx = 3'd6;
    #1;
    check("R10 y old value", 32'(rd_val), 32'h0066);
    step(1'b0, 3'd0, 16'h0, 1'b1);
    check("R6 y in next snapshot", 32'(frz_flags), 32'h40);
    check("R6 y new value", 32'(rd_val), 32'h0166);

    // R8: heavy emits without commit leave the frozen bank alone
    for (int k = 0; k < NUM_EVT; k++) step(1'b1, IDX_W'(k), 16'hBEEF, 1'b0);
    check("R8 flags hold", 32'(frz_flags), 32'h40);
    check("R8 value hold", 32'(rd_val), 32'h0166);

    // R1: reset mid-run clears both banks
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 frozen cleared", 32'(frz_flags), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 3'd0, 16'h0, 1'b1);
    check("R1 live cleared", 32'(frz_flags), 32'h0);
    for (int k = 0; k < NUM_EVT; k++) begin
      rd_idx = IDX_W'(k);
      #0.2;
      check($sformatf("R1 value %0d", k), 32'(rd_val), 32'h0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule